// File: doc/BRIEF.md
# Receive-side stream upsizer with clock crossing

This block moves packets from a narrow receive path into a wide application path. Packet beats arrive 32 bits at a time in the receive clock domain with a 4-bit byte enable. A packer pairs consecutive beats into one 64-bit word, the first beat in the low half and the second in the high half. It compresses the byte enable into a 3-bit code and stores the word, together with a last flag and an error flag, in a register-based asynchronous first-word-fall-through FIFO. On the user clock side a read controller turns each stored word back into one 64-bit stream beat with an 8-bit keep, a last flag and an error sideband.

The receive path cannot be stalled, so the packer protects the FIFO itself. A packet that grows past a byte limit, or that arrives while the FIFO is nearly full, is cut short. The packer writes one closing word marked both last and erroneous, then discards the rest of that packet up to its final beat. The read controller presents the first available word without waiting for ready, and afterwards advances only on accepted beats.

Top module: `strm_upsizer`

## Requirements
- R1: Two consecutive valid input beats of a packet form one output beat. The first beat fills data bits [31:0] and the second fills bits [63:32].
- R2: Output keep is contiguous from bit 0. Its population equals the number of valid bytes in the word: 4 times the beats before the last beat of the word, plus the set bits of the last beat's input keep (0001, 0011, 0111 or 1111). In the FIFO word, data sits at [63:0], the keep code at [66:64], error at [67] and last at [68]. The keep code is the byte count minus one.
- R3: A last beat that lands in the low half is written at once as a word with data bits [63:32] zero and keep at most 0Fh. The next packet starts again in the low half.
- R4: Cycles with input valid low between beats do not change the packing, the data or the keep of any output beat.
- R5: When the beat being received would bring the packet past MAX_BYTES bytes, that beat is not stored. Any pending low half is discarded. A closing word is emitted with last=1, user=1, keep=01h and data zero; earlier complete words pass unchanged.
- R6: After an abort, input beats are discarded up to and including the packet's last beat. The next packet is carried normally.
- R7: When a beat arrives while fewer than LOW_WATER FIFO entries are free, the packet is aborted in the same way as in R5, if at least one entry is free.
- R8: While output valid is high and ready is low, valid, data, keep, last and user hold their values.
- R9: With ready held low, the first stored word still appears on the output, with valid high, once the FIFO is not empty.
- R10: Output valid is low after reset. It drops after the last held beat is accepted and the FIFO is empty. The FIFO is never written when full nor read when empty.
- R11: A packet of exactly MAX_BYTES bytes passes complete and without the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mac_clk | input | 1 | Receive-side clock |
| mac_rst | input | 1 | Synchronous active-high reset, receive domain |
| rx_valid | input | 1 | Input beat valid |
| rx_data | input | 32 | Input beat data, byte 0 in bits [7:0] |
| rx_keep | input | 4 | Input byte enable, contiguous from bit 0 |
| rx_last | input | 1 | Final beat of the packet |
| usr_clk | input | 1 | User-side clock |
| usr_rst | input | 1 | Synchronous active-high reset, user domain |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Output beat accepted |
| m_data | output | 64 | Output beat data |
| m_keep | output | 8 | Output byte enable |
| m_last | output | 1 | Final beat of the packet |
| m_user | output | 1 | Packet was cut short by the block |

## Verification
The bench builds the block with a 40-byte packet limit, a 16-entry FIFO and a low-water mark of 8. These settings let short packets reach the oversize cut, and the exact-limit case, within ten input beats. They also let a stalled consumer bring the FIFO below the low-water mark within three packets, so the R7 abort happens at a beat the bench can predict. The user clock runs at a different rate from the receive clock, so the pointer synchronizers see real phase drift.

// File: rtl/strm_pkg.sv
package strm_pkg;

  // one stored FIFO entry; field order fixes the bit positions
  typedef struct packed {
    logic        last;   // [68]
    logic        err;    // [67]
    logic [2:0]  kcode;  // [66:64] byte count minus one
    logic [63:0] data;   // [63:0]
  } fifo_word_t;

  localparam int WORD_W = $bits(fifo_word_t);

  // 4-bit contiguous byte enable to a 2-bit byte-count-minus-one code
  function automatic logic [1:0] enc_keep4(input logic [3:0] k);
    logic [1:0] c;
    case (k)
      4'b0001: c = 2'b00;
      4'b0011: c = 2'b01;
      4'b0111: c = 2'b10;
      default: c = 2'b11;
    endcase
    return c;
  endfunction

  function automatic logic [2:0] beat_bytes(input logic [3:0] k);
    return {1'b0, enc_keep4(k)} + 3'd1;
  endfunction

  // 3-bit code back to an 8-bit contiguous keep
  function automatic logic [7:0] dec_kcode(input logic [2:0] c);
    logic [3:0] sh;
    logic [8:0] t;
    sh = {1'b0, c} + 4'd1;
    t  = (9'd1 << sh) - 9'd1;
    return t[7:0];
  endfunction

endpackage

// File: rtl/pk_packer.sv
module pk_packer
  import strm_pkg::*;
#(
  parameter int MAX_BYTES = 9014,
  parameter int LOW_WATER = 8,
  parameter int FREE_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       in_data,
  input  logic [3:0]        in_keep,
  input  logic              in_last,
  input  logic [FREE_W-1:0] free_words,
  output logic              wr_en,
  output fifo_word_t        wr_word
);

  localparam int CNT_W = $clog2(MAX_BYTES + 5);

  logic             half_q;
  logic             drop_q;
  logic [31:0]      lo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_en_q;
  fifo_word_t       word_q;

  logic [CNT_W-1:0]  cnt_next;
  logic [FREE_W-1:0] free_eff;
  logic              too_long;
  logic              low_space;
  logic              can_put;
  logic [1:0]        kc;

  always_comb begin
    kc        = enc_keep4(in_keep);
    cnt_next  = cnt_q + CNT_W'(beat_bytes(in_keep));
    too_long  = int'(cnt_next) > MAX_BYTES;
    free_eff  = free_words - FREE_W'(wr_en_q);
    low_space = int'(free_eff) < LOW_WATER;
    can_put   = free_eff != '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q  <= 1'b0;
      drop_q  <= 1'b0;
      lo_q    <= '0;
      cnt_q   <= '0;
      wr_en_q <= 1'b0;
      word_q  <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (in_valid) begin
        if (drop_q) begin
          if (in_last) drop_q <= 1'b0;
        end else if (too_long || low_space) begin
          wr_en_q      <= can_put;
          word_q.last  <= 1'b1;
          word_q.err   <= 1'b1;
          word_q.kcode <= 3'b000;
          word_q.data  <= '0;
          drop_q       <= !in_last;
          half_q       <= 1'b0;
          cnt_q        <= '0;
        end else if (!half_q) begin
          lo_q  <= in_data;
          cnt_q <= in_last ? '0 : cnt_next;
          if (in_last) begin
            wr_en_q      <= 1'b1;
            word_q.last  <= 1'b1;
            word_q.err   <= 1'b0;
            word_q.kcode <= {1'b0, kc};
            word_q.data  <= {32'h0, in_data};
          end else begin
            half_q <= 1'b1;
          end
        end else begin
          wr_en_q      <= 1'b1;
          word_q.last  <= in_last;
          word_q.err   <= 1'b0;
          word_q.kcode <= {1'b1, kc};
          word_q.data  <= {in_data, lo_q};
          half_q       <= 1'b0;
          cnt_q        <= in_last ? '0 : cnt_next;
        end
      end
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_word = word_q;

  // R3: a last beat always leaves the packer ready for a low half
  p_low_after_last_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_last |=> !half_q);

  // R6: beats seen while discarding never produce a write
  p_drop_silent_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && drop_q |=> !wr_en_q);

  // R10: a pending write always has a free entry reported by the FIFO
  p_write_room_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en_q |-> free_words != '0);

endmodule

// File: rtl/af_fifo.sv
module af_fifo #(
  parameter int W     = 69,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          wr_en,
  input  logic [W-1:0]  wdata,
  output logic [PW-1:0] free,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          rd_en,
  output logic [W-1:0]  rdata,
  output logic          empty
);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rgray_s1, rgray_s2;
  logic [PW-1:0] rbin, rgray, wgray_s1, wgray_s2;
  logic          full;
  logic [PW-1:0] wnext, rnext;

  // write domain
  always_comb begin
    free  = PW'(DEPTH) - (wbin - from_gray(rgray_s2));
    full  = free == '0;
    wnext = wbin + PW'(1);
  end

  always_ff @(posedge wclk) begin
    if (wr_en && !full) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin     <= '0;
      wgray    <= '0;
      rgray_s1 <= '0;
      rgray_s2 <= '0;
    end else begin
      rgray_s1 <= rgray;
      rgray_s2 <= rgray_s1;
      if (wr_en && !full) begin
        wbin  <= wnext;
        wgray <= to_gray(wnext);
      end
    end
  end

  // read domain, first word falls through
  always_comb begin
    empty = rgray == wgray_s2;
    rnext = rbin + PW'(1);
    rdata = mem[rbin[AW-1:0]];
  end

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin     <= '0;
      rgray    <= '0;
      wgray_s1 <= '0;
      wgray_s2 <= '0;
    end else begin
      wgray_s1 <= wgray;
      wgray_s2 <= wgray_s1;
      if (rd_en && !empty) begin
        rbin  <= rnext;
        rgray <= to_gray(rnext);
      end
    end
  end

  p_no_overflow_r10: assert property (@(posedge wclk) disable iff (wrst)
    wr_en |-> !full);

  p_no_underflow_r10: assert property (@(posedge rclk) disable iff (rrst)
    rd_en |-> !empty);

endmodule

// File: rtl/rc_reader.sv
module rc_reader
  import strm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ff_empty,
  input  fifo_word_t  ff_word,
  output logic        ff_rd,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [63:0] m_data,
  output logic [7:0]  m_keep,
  output logic        m_last,
  output logic        m_user
);

  logic armed_q;

  // eager path while armed, otherwise only on an accepted beat
  assign ff_rd = !ff_empty && (armed_q || m_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b1;
      m_valid <= 1'b0;
      m_data  <= '0;
      m_keep  <= '0;
      m_last  <= 1'b0;
      m_user  <= 1'b0;
    end else if (ff_rd) begin
      armed_q <= 1'b0;
      m_valid <= 1'b1;
      m_data  <= ff_word.data;
      m_keep  <= dec_kcode(ff_word.kcode);
      m_last  <= ff_word.last;
      m_user  <= ff_word.err;
    end else if (m_valid && m_ready) begin
      armed_q <= 1'b1;
      m_valid <= 1'b0;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_keep)
                            && $stable(m_last) && $stable(m_user));

  p_keep_shape_r2: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> m_keep[0] && ((m_keep & (m_keep + 8'd1)) == 8'd0));

  p_eager_r9: assert property (@(posedge clk) disable iff (rst)
    !m_valid && !ff_empty |=> m_valid);

endmodule

// File: rtl/strm_upsizer.sv
module strm_upsizer
  import strm_pkg::*;
#(
  parameter int MAX_BYTES  = 9014,
  parameter int LOW_WATER  = 8,
  parameter int FIFO_DEPTH = 32
) (
  input  logic        mac_clk,
  input  logic        mac_rst,
  input  logic        rx_valid,
  input  logic [31:0] rx_data,
  input  logic [3:0]  rx_keep,
  input  logic        rx_last,
  input  logic        usr_clk,
  input  logic        usr_rst,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [63:0] m_data,
  output logic [7:0]  m_keep,
  output logic        m_last,
  output logic        m_user
);

  localparam int PW = $clog2(FIFO_DEPTH) + 1;

  logic          wr_en;
  fifo_word_t    wr_word;
  logic [PW-1:0] free_words;
  logic          rd_en;
  logic          ff_empty;
  fifo_word_t    rd_word;

  pk_packer #(
    .MAX_BYTES (MAX_BYTES),
    .LOW_WATER (LOW_WATER),
    .FREE_W    (PW)
  ) u_packer (
    .clk        (mac_clk),
    .rst        (mac_rst),
    .in_valid   (rx_valid),
    .in_data    (rx_data),
    .in_keep    (rx_keep),
    .in_last    (rx_last),
    .free_words (free_words),
    .wr_en      (wr_en),
    .wr_word    (wr_word)
  );

  af_fifo #(
    .W     (WORD_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .wclk  (mac_clk),
    .wrst  (mac_rst),
    .wr_en (wr_en),
    .wdata (wr_word),
    .free  (free_words),
    .rclk  (usr_clk),
    .rrst  (usr_rst),
    .rd_en (rd_en),
    .rdata (rd_word),
    .empty (ff_empty)
  );

  rc_reader u_reader (
    .clk      (usr_clk),
    .rst      (usr_rst),
    .ff_empty (ff_empty),
    .ff_word  (rd_word),
    .ff_rd    (rd_en),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_data   (m_data),
    .m_keep   (m_keep),
    .m_last   (m_last),
    .m_user   (m_user)
  );

endmodule

// File: tb/test_strm_upsizer.sv
`timescale 1ns/100ps
module test_strm_upsizer;

  localparam int TB_MAX   = 40;
  localparam int TB_LOW   = 8;
  localparam int TB_DEPTH = 16;

  logic        mac_clk = 1'b0;
  logic        usr_clk = 1'b0;
  logic        mac_rst = 1'b1;
  logic        usr_rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [31:0] rx_data = '0;
  logic [3:0]  rx_keep = '0;
  logic        rx_last = 1'b0;
  logic        m_ready = 1'b0;
  logic        m_valid;
  logic [63:0] m_data;
  logic [7:0]  m_keep;
  logic        m_last;
  logic        m_user;

  typedef struct packed {
    logic [63:0] d;
    logic [7:0]  k;
    logic        l;
    logic        u;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  int    ready_pct = 100;

  always #5   mac_clk = ~mac_clk;   // 100 MHz
  always #3.5 usr_clk = ~usr_clk;

  strm_upsizer #(
    .MAX_BYTES  (TB_MAX),
    .LOW_WATER  (TB_LOW),
    .FIFO_DEPTH (TB_DEPTH)
  ) i_strm_upsizer (
    .mac_clk  (mac_clk),
    .mac_rst  (mac_rst),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_keep  (rx_keep),
    .rx_last  (rx_last),
    .usr_clk  (usr_clk),
    .usr_rst  (usr_rst),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_data   (m_data),
    .m_keep   (m_keep),
    .m_last   (m_last),
    .m_user   (m_user)
  );

  always @(posedge usr_clk) begin
    #1;
    m_ready <= int'($urandom % 100) < ready_pct;
  end

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // scoreboard on every accepted output beat
  always @(negedge usr_clk) begin
    if (!usr_rst && m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "beat with nothing expected", m_data, 64'h0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(m_data === e.d && m_keep === e.k && m_last === e.l && m_user === e.u,
            t, "beat {data,keep,last,user}",
            {m_data[53:0], m_keep, m_last, m_user}, {e.d[53:0], e.k, e.l, e.u});
      end
    end
  end

  task automatic push_exp(input logic [63:0] d, input logic [7:0] k,
                          input logic l, input logic u, input string tag);
    exp_t e;
    e.d = d; e.k = k; e.l = l; e.u = u;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // expected output words from the packet bytes (R1, R2, R3, R5)
  task automatic build_exp(input logic [7:0] pb[$], input string tag);
    int n;
    n = pb.size();
    if (n <= TB_MAX) begin
      int nw;
      nw = (n + 7) / 8;
      for (int w = 0; w < nw; w++) begin
        logic [63:0] d;
        int cnt;
        d = '0; cnt = 0;
        for (int j = 0; j < 8; j++) begin
          if (8 * w + j < n) begin
            d[8*j +: 8] = pb[8 * w + j];
            cnt++;
          end
        end
        push_exp(d, (cnt == 8) ? 8'hFF : 8'((1 << cnt) - 1), w == nw - 1, 1'b0, tag);
      end
    end else begin
      int nbeats, ok;
      nbeats = (n + 3) / 4;
      ok = (TB_MAX / 4 < nbeats - 1) ? TB_MAX / 4 : nbeats - 1;
      for (int w = 0; w < ok / 2; w++) begin
        logic [63:0] d;
        for (int j = 0; j < 8; j++) d[8*j +: 8] = pb[8 * w + j];
        push_exp(d, 8'hFF, 1'b0, 1'b0, tag);
      end
      push_exp(64'h0, 8'h01, 1'b1, 1'b1, tag);
    end
  endtask

  // call with time just after a rising mac_clk edge
  task automatic send_pkt(input int n, input int gap_pct, input string tag,
                          input bit abort_only);
    logic [7:0] pb[$];
    int nb;
    for (int i = 0; i < n; i++) pb.push_back(8'($urandom));
    if (abort_only) push_exp(64'h0, 8'h01, 1'b1, 1'b1, tag);
    else build_exp(pb, tag);
    nb = (n + 3) / 4;
    for (int b = 0; b < nb; b++) begin
      int r;
      logic [31:0] d;
      while (int'($urandom % 100) < gap_pct) begin
        rx_valid = 1'b0;
        rx_data  = 32'hDEAD_BEEF;
        @(posedge mac_clk); #1;
      end
      r = (n - 4 * b < 4) ? n - 4 * b : 4;
      d = '0;
      for (int j = 0; j < r; j++) d[8*j +: 8] = pb[4 * b + j];
      rx_valid = 1'b1;
      rx_data  = d;
      rx_keep  = 4'((1 << r) - 1);
      rx_last  = (b == nb - 1);
      @(posedge mac_clk); #1;
    end
    rx_valid = 1'b0;
    rx_last  = 1'b0;
  endtask

  task automatic wait_drain(input string tag);
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 5000) begin
      @(posedge usr_clk);
      t++;
    end
    chk(exp_q.size() == 0, tag, "words left undelivered", 64'(exp_q.size()), 64'h0);
    repeat (20) @(posedge usr_clk);
    @(posedge mac_clk); #1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge mac_clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [63:0] first_d;
    void'($urandom(32'h5EED_0017));
    repeat (6) @(posedge mac_clk);
    #1;
    mac_rst = 1'b0;
    usr_rst = 1'b0;
    repeat (4) @(posedge mac_clk);
    #1;
    // R10: nothing presented after reset
    chk(m_valid === 1'b0, "R10", "valid after reset", 64'(m_valid), 64'h0);

    // R11: exactly the byte limit, R1: plain pairing
    send_pkt(TB_MAX, 0, "R11", 1'b0);
    send_pkt(16, 0, "R1", 1'b0);
    // R2: every tail length; R3: odd beat counts end in the low half
    for (int n = 1; n <= 16; n++) send_pkt(n, 0, "R2", 1'b0);
    send_pkt(12, 0, "R3", 1'b0);
    send_pkt(3, 0, "R3", 1'b0);
    wait_drain("R2");

    // R5 oversize cuts, R6 normal packets right after them
    send_pkt(48, 0, "R5", 1'b0);
    send_pkt(8, 0, "R6", 1'b0);
    send_pkt(TB_MAX + 1, 0, "R5", 1'b0);
    send_pkt(20, 0, "R6", 1'b0);
    send_pkt(45, 20, "R5", 1'b0);
    send_pkt(13, 0, "R6", 1'b0);
    wait_drain("R5");

    // R4: random lengths, gaps and back-pressure
    ready_pct = 75;
    for (int p = 0; p < 60; p++)
      send_pkt(1 + int'($urandom % TB_MAX), 30, "R4", 1'b0);
    wait_drain("R4");

    // R9, R8, R7: stalled consumer fills the FIFO below the low-water mark
    ready_pct = 0;
    repeat (4) @(posedge usr_clk);
    @(posedge mac_clk); #1;
    send_pkt(36, 0, "R9", 1'b0);
    send_pkt(TB_MAX, 0, "R7", 1'b0);
    send_pkt(TB_MAX, 0, "R7", 1'b1);
    repeat (20) @(posedge mac_clk);
    @(negedge usr_clk);
    first_d = exp_q[0].d;
    chk(m_valid === 1'b1, "R9", "eager first word valid", 64'(m_valid), 64'h1);
    chk(m_data === first_d, "R9", "eager first word data", m_data, first_d);
    repeat (10) @(negedge usr_clk);
    chk(m_valid === 1'b1 && m_data === first_d, "R8", "held beat under stall",
        m_data, first_d);
    ready_pct = 100;
    wait_drain("R7");
    send_pkt(24, 0, "R7", 1'b0);
    wait_drain("R7");

    // R10: valid falls once everything is taken
    @(negedge usr_clk);
    chk(m_valid === 1'b0, "R10", "valid after drain", 64'(m_valid), 64'h0);
    finish_run();
  end

endmodule